// File: doc/BRIEF.md
# Nibble-Addressed DAC Write Sequencer

This block sits on the host side of a double-buffered, voltage-output converter that has a 10-bit code. The converter loads its code through a narrow parallel bus. That bus has two address lines, an 8-bit data path, an active-low select, an active-low write strobe and an active-low load line. The converter's input latch is 12 bits wide. The 10-bit code sits above two sub-LSB bits that must always be zero. The latch is split into a low, a middle and a high nibble, and each nibble is written through its own address.

A request is a 10-bit code, presented with a valid/ready handshake. Two mode bits go with it. `req_wide` selects the 8-bit path, which writes the word in two cycles (8 + 4). When it is clear, the 4-bit path writes the word in three cycles (4 + 4 + 4). `req_transparent` keeps the load line low for the whole transaction, so the converter output follows each write. When it is clear, the load line stays high during the writes and one load pulse follows them. Setup, strobe, hold and load widths are parameters counted in system clock cycles. A one-cycle `done` pulse marks the end of each transaction.

The state machine has six states. ST_IDLE has ready high and the bus quiet. ST_SETUP drives select, address and data with the strobe high. ST_STROBE holds the write strobe low. ST_HOLD raises the strobe and keeps address and data steady. ST_LOAD pulses the load line. ST_DONE raises `done`.

The transitions are as follows:
- ST_IDLE moves to ST_SETUP when a request is accepted.
- ST_SETUP moves to ST_STROBE, and ST_STROBE moves to ST_HOLD, each when its interval runs out.
- ST_HOLD moves back to ST_SETUP if another write cycle remains.
- After the last write, ST_HOLD moves to ST_LOAD in pulsed mode, or to ST_DONE in transparent mode.
- ST_LOAD moves to ST_DONE.
- ST_DONE returns to ST_IDLE.

Top module: `nibble_dac_writer`

## Requirements
- R1: After reset and whenever idle, `bus_cs_n`, `bus_wr_n` and `bus_ld_n` are high, `req_ready` is 1, `done` is 0, and `bus_addr` and `bus_data` are zero.
- R2: The code, `req_wide` and `req_transparent` are captured when a request is accepted. Changes on those inputs afterwards do not alter the transaction in progress.
- R3: With `req_wide`=0, three write cycles are issued. The address is written as {A1,A0} on `bus_addr[1:0]`. The order is: address 2'b11 carrying word[11:8], then 2'b01 carrying word[7:4], then 2'b10 carrying word[3:0]. Each nibble sits on `bus_data[3:0]`, with `bus_data[7:4]` zero.
- R4: With `req_wide`=1 and `req_transparent`=1, the first write is address 2'b00 carrying word[7:0]. The second write is address 2'b11 carrying word[11:8] on `bus_data[3:0]`.
- R5: With `req_wide`=1 and `req_transparent`=0, the two writes are issued in the other order: address 2'b11 first, then 2'b00.
- R6: The 12-bit word is {code, 2'b00}, so the two sub-LSB bits are always written as zero.
- R7: Each write cycle has three phases. First come SETUP_CYC cycles with the strobe high, then PULSE_CYC cycles with the strobe low, then HOLD_CYC cycles with the strobe high. Address and data stay constant across all three phases.
- R8: `bus_cs_n` is low exactly during write-cycle phases. The write strobe is never low while select is high.
- R9: In pulsed mode, `bus_ld_n` stays high during the writes. After the last hold phase it goes low for LOAD_CYC cycles, with select and strobe high.
- R10: In transparent mode, `bus_ld_n` is low from the first setup phase through the last hold phase, and no separate load pulse follows.
- R11: `req_ready` is high only in the idle state. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. A valid held high while busy is not taken until the idle state returns.
- R12: `done` is high for exactly one cycle, right after the last hold phase (transparent) or the load pulse (pulsed). The block is idle on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_code | input | 10 | Converter code |
| req_wide | input | 1 | 1: 8 + 4 path, 0: 4 + 4 + 4 path |
| req_transparent | input | 1 | 1: load line held low, 0: load pulse after the writes |
| bus_addr | output | 2 | Nibble address, bit 0 = A0, bit 1 = A1 |
| bus_data | output | 8 | Write data |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_ld_n | output | 1 | Load line, active low |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench aims at the ordering difference between the two 8-bit variants. A design that ignored the load choice would write the high nibble first in transparent mode, so the converter would briefly output a code made of the new high nibble and stale low bits. Codes 0, all ones and the alternating patterns expose swapped or shifted nibbles, and a sub-LSB written as one. Inputs are scrambled right after acceptance to catch a design that reads the live inputs instead of its capture. A valid held high through a transaction catches a block that accepts a second request while busy or drops the request that is waiting.

// File: rtl/ndw_pkg.sv
package ndw_pkg;

    localparam int CODE_W = 10;
    localparam int WORD_W = CODE_W + 2;
    localparam int BUS_W  = 8;
    localparam int ADDR_W = 2;
    localparam int STEP_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_LOAD,
        ST_DONE
    } ndw_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BUS_W-1:0]  data;
        logic              last;
    } ndw_step_t;

endpackage

// File: rtl/ndw_interval_timer.sv
module ndw_interval_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_q;

    // Reloaded with len-1 on every state change, so a phase lasts len cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= len_i - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/ndw_step_plan.sv
module ndw_step_plan
    import ndw_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic              wide_i,
    input  logic              transparent_i,
    input  logic [STEP_W-1:0] step_i,
    output ndw_step_t         step_o
);

    localparam logic [ADDR_W-1:0] ADR_HIGH = 2'b11;
    localparam logic [ADDR_W-1:0] ADR_MID  = 2'b01;
    localparam logic [ADDR_W-1:0] ADR_LOW  = 2'b10;
    localparam logic [ADDR_W-1:0] ADR_BYTE = 2'b00;

    logic [BUS_W-1:0] nib_high;
    logic [BUS_W-1:0] nib_mid;
    logic [BUS_W-1:0] nib_low;
    logic [BUS_W-1:0] byte_lo;

    assign nib_high = {4'h0, word_i[11:8]};
    assign nib_mid  = {4'h0, word_i[7:4]};
    assign nib_low  = {4'h0, word_i[3:0]};
    assign byte_lo  = word_i[7:0];

    always_comb begin
        step_o = '{addr: ADR_HIGH, data: nib_high, last: 1'b0};
        if (!wide_i) begin
            case (step_i)
                2'd0:    step_o = '{addr: ADR_HIGH, data: nib_high, last: 1'b0};
                2'd1:    step_o = '{addr: ADR_MID,  data: nib_mid,  last: 1'b0};
                default: step_o = '{addr: ADR_LOW,  data: nib_low,  last: 1'b1};
            endcase
        end else if (transparent_i) begin
            // Load line open: the low byte must land before the high nibble.
            if (step_i == '0) step_o = '{addr: ADR_BYTE, data: byte_lo,  last: 1'b0};
            else              step_o = '{addr: ADR_HIGH, data: nib_high, last: 1'b1};
        end else begin
            if (step_i == '0) step_o = '{addr: ADR_HIGH, data: nib_high, last: 1'b0};
            else              step_o = '{addr: ADR_BYTE, data: byte_lo,  last: 1'b1};
        end
    end

endmodule

// File: rtl/nibble_dac_writer.sv
module nibble_dac_writer
    import ndw_pkg::*;
#(
    parameter int SETUP_CYC = 3,
    parameter int PULSE_CYC = 3,
    parameter int HOLD_CYC  = 2,
    parameter int LOAD_CYC  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CODE_W-1:0] req_code,
    input  logic              req_wide,
    input  logic              req_transparent,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BUS_W-1:0]  bus_data,
    output logic              bus_cs_n,
    output logic              bus_wr_n,
    output logic              bus_ld_n,
    output logic              done
);

    localparam int MAX_SP  = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int MAX_HL  = (HOLD_CYC > LOAD_CYC) ? HOLD_CYC : LOAD_CYC;
    localparam int MAX_CYC = (MAX_SP > MAX_HL) ? MAX_SP : MAX_HL;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    ndw_state_e        state_q, state_d;
    logic [WORD_W-1:0] word_q;
    logic              wide_q;
    logic              transparent_q;
    logic [STEP_W-1:0] step_q;
    logic [CNT_W-1:0]  phase_len;
    logic              phase_over;
    logic              restart;
    logic              accept;
    ndw_step_t         plan;

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign restart = (state_d != state_q);

    ndw_step_plan u_plan (
        .word_i        (word_q),
        .wide_i        (wide_q),
        .transparent_i (transparent_q),
        .step_i        (step_q),
        .step_o        (plan)
    );

    ndw_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .len_i     (phase_len),
        .expired_o (phase_over)
    );

    always_comb begin
        unique case (state_d)
            ST_SETUP:  phase_len = CNT_W'(SETUP_CYC);
            ST_STROBE: phase_len = CNT_W'(PULSE_CYC);
            ST_HOLD:   phase_len = CNT_W'(HOLD_CYC);
            ST_LOAD:   phase_len = CNT_W'(LOAD_CYC);
            default:   phase_len = CNT_W'(1);
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request capture and write-cycle index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q        <= '0;
            wide_q        <= 1'b0;
            transparent_q <= 1'b0;
            step_q        <= '0;
        end else if (accept) begin
            word_q        <= {req_code, 2'b00};
            wide_q        <= req_wide;
            transparent_q <= req_transparent;
            step_q        <= '0;
        end else if (state_q == ST_HOLD && state_d == ST_SETUP) begin
            step_q        <= step_q + STEP_W'(1);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid)  state_d = ST_SETUP;
            ST_SETUP:  if (phase_over) state_d = ST_STROBE;
            ST_STROBE: if (phase_over) state_d = ST_HOLD;
            ST_HOLD: begin
                if (phase_over) begin
                    if (!plan.last)        state_d = ST_SETUP;
                    else if (transparent_q) state_d = ST_DONE;
                    else                   state_d = ST_LOAD;
                end
            end
            ST_LOAD:   if (phase_over) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
        endcase
    end

    // Output decode.
    always_comb begin
        req_ready = 1'b0;
        bus_addr  = '0;
        bus_data  = '0;
        bus_cs_n  = 1'b1;
        bus_wr_n  = 1'b1;
        bus_ld_n  = 1'b1;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_SETUP, ST_STROBE, ST_HOLD: begin
                bus_addr = plan.addr;
                bus_data = plan.data;
                bus_cs_n = 1'b0;
                bus_wr_n = (state_q != ST_STROBE);
                bus_ld_n = !transparent_q;
            end
            ST_LOAD: bus_ld_n = 1'b0;
            ST_DONE: done = 1'b1;
        endcase
    end

endmodule

// File: rtl/ndw_checker.sv
module ndw_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_data,
    input logic       bus_cs_n,
    input logic       bus_wr_n,
    input logic       bus_ld_n,
    input logic       done
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_cs_n && bus_wr_n && bus_ld_n && !done)); // R1

    AST_NIBBLE_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && bus_addr != 2'b00) |-> (bus_data[7:4] == 4'h0)); // R3

    AST_SUBLSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && bus_addr == 2'b00) |-> (bus_data[1:0] == 2'b00)); // R6

    AST_STROBE_BUS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr_n && !$past(bus_wr_n)) |-> ($stable(bus_addr) && $stable(bus_data))); // R7

    AST_STROBE_UNDER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_n |-> !bus_cs_n); // R8

    AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R11

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12

endmodule

bind nibble_dac_writer ndw_checker u_ndw_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .bus_addr  (bus_addr),
    .bus_data  (bus_data),
    .bus_cs_n  (bus_cs_n),
    .bus_wr_n  (bus_wr_n),
    .bus_ld_n  (bus_ld_n),
    .done      (done)
);

// File: tb/nibble_dac_writer_bench.sv
module nibble_dac_writer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int S_CYC = 2;
    localparam int P_CYC = 3;
    localparam int H_CYC = 1;
    localparam int L_CYC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [9:0] req_code = '0;
    logic       req_wide = 1'b0;
    logic       req_transparent = 1'b0;
    logic [1:0] bus_addr;
    logic [7:0] bus_data;
    logic       bus_cs_n, bus_wr_n, bus_ld_n, done;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nibble_dac_writer #(
        .SETUP_CYC (S_CYC),
        .PULSE_CYC (P_CYC),
        .HOLD_CYC  (H_CYC),
        .LOAD_CYC  (L_CYC)
    ) u_nibble_dac_writer (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid       (req_valid),
        .req_ready       (req_ready),
        .req_code        (req_code),
        .req_wide        (req_wide),
        .req_transparent (req_transparent),
        .bus_addr        (bus_addr),
        .bus_data        (bus_data),
        .bus_cs_n        (bus_cs_n),
        .bus_wr_n        (bus_wr_n),
        .bus_ld_n        (bus_ld_n),
        .done            (done)
    );

    // mode: 0 narrow, 1 wide transparent, 2 wide pulsed, 3 idle
    typedef struct packed {
        logic [1:0] mode;
        logic [1:0] addr;
        logic [7:0] data;
        logic       cs_n;
        logic       wr_n;
        logic       ld_n;
        logic       rdy;
        logic       dn;
    } ev_t;

    localparam ev_t IDLE_EV = '{mode: 2'd3, addr: 2'b00, data: 8'h00,
                                cs_n: 1'b1, wr_n: 1'b1, ld_n: 1'b1, rdy: 1'b1, dn: 1'b0};

    ev_t exp_q[$];
    ev_t cur = IDLE_EV;

    function automatic ev_t mk(logic [1:0] m, logic [1:0] a, logic [7:0] d,
                               logic c, logic w, logic l, logic r, logic n);
        ev_t e;
        e.mode = m; e.addr = a; e.data = d;
        e.cs_n = c; e.wr_n = w; e.ld_n = l; e.rdy = r; e.dn = n;
        return e;
    endfunction

    task automatic add_write(logic [1:0] m, logic [1:0] a, logic [7:0] d, logic l);
        for (int i = 0; i < S_CYC; i++) exp_q.push_back(mk(m, a, d, 1'b0, 1'b1, l, 1'b0, 1'b0));
        for (int i = 0; i < P_CYC; i++) exp_q.push_back(mk(m, a, d, 1'b0, 1'b0, l, 1'b0, 1'b0));
        for (int i = 0; i < H_CYC; i++) exp_q.push_back(mk(m, a, d, 1'b0, 1'b1, l, 1'b0, 1'b0));
    endtask

    task automatic plan_txn(logic [9:0] code, logic wide, logic tr);
        logic [11:0] w;
        logic [1:0]  m;
        w = {code, 2'b00};
        m = !wide ? 2'd0 : (tr ? 2'd1 : 2'd2);
        if (!wide) begin
            add_write(m, 2'b11, {4'h0, w[11:8]}, !tr);
            add_write(m, 2'b01, {4'h0, w[7:4]},  !tr);
            add_write(m, 2'b10, {4'h0, w[3:0]},  !tr);
        end else if (tr) begin
            add_write(m, 2'b00, w[7:0],          1'b0);
            add_write(m, 2'b11, {4'h0, w[11:8]}, 1'b0);
        end else begin
            add_write(m, 2'b11, {4'h0, w[11:8]}, 1'b1);
            add_write(m, 2'b00, w[7:0],          1'b1);
        end
        if (!tr)
            for (int i = 0; i < L_CYC; i++) exp_q.push_back(mk(m, 2'b00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0));
        exp_q.push_back(mk(m, 2'b00, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1));
    endtask

    function automatic string pick_tag(ev_t e, ev_t a);
        if (e.rdy != a.rdy) return "R11";
        if (e.dn != a.dn)   return "R12";
        if (e.mode == 2'd3) return "R1";
        if (e.addr != a.addr) return (e.mode == 2'd0) ? "R3" : (e.mode == 2'd1) ? "R4" : "R5";
        if (e.data != a.data) return "R6";
        if (e.wr_n != a.wr_n) return "R7";
        if (e.cs_n != a.cs_n) return "R8";
        return (e.mode == 2'd1) ? "R10" : "R9";
    endfunction

    task automatic chk(logic ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle reference model, compared away from the active edge.
    always @(negedge clk) begin
        ev_t act;
        if (!rst_n) begin
            cur = IDLE_EV;
        end else begin
            act = mk(cur.mode, bus_addr, bus_data, bus_cs_n, bus_wr_n, bus_ld_n, req_ready, done);
            checks++;
            if (act != cur) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h at %0t", pick_tag(cur, act), act, cur, $time);
            end
            if (exp_q.size() > 0) begin
                cur = exp_q.pop_front();
            end else if (cur.rdy && req_valid) begin
                plan_txn(req_code, req_wide, req_transparent);
                cur = exp_q.pop_front();
            end else begin
                cur = IDLE_EV;
            end
        end
    end

    task automatic wait_ready;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
    endtask

    task automatic wait_done;
        do @(negedge clk); while (!done);
    endtask

    task automatic send(logic [9:0] code, logic wide, logic tr, logic scramble, logic keep_valid);
        int snap;
        snap = errors;
        @(posedge clk); #1;
        req_code = code; req_wide = wide; req_transparent = tr; req_valid = 1'b1;
        wait_ready;
        if (!keep_valid) req_valid = 1'b0;
        if (scramble) begin
            req_code = ~code; req_wide = !wide; req_transparent = !tr;
        end
        wait_done;
        if (keep_valid) begin
            // R11: the second request waits for idle, then is taken once.
            wait_ready;
            req_valid = 1'b0;
            wait_done;
            chk(errors == snap, "R11", 32'(errors - snap), 32'd0);
        end
        if (scramble) chk(errors == snap, "R2", 32'(errors - snap), 32'd0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports.
        chk(bus_cs_n && bus_wr_n && bus_ld_n && req_ready && !done &&
            bus_addr == 2'b00 && bus_data == 8'h00, "R1",
            {19'd0, bus_addr, bus_data, bus_cs_n, bus_wr_n, bus_ld_n}, {19'd0, 10'd0, 3'b111});
        // R3 narrow, both load choices
        send(10'h3FF, 1'b0, 1'b0, 1'b0, 1'b0);
        send(10'h2AA, 1'b0, 1'b1, 1'b0, 1'b0);
        send(10'h000, 1'b0, 1'b0, 1'b0, 1'b0);
        // R4 wide transparent ordering
        send(10'h155, 1'b1, 1'b1, 1'b0, 1'b0);
        send(10'h3FF, 1'b1, 1'b1, 1'b0, 1'b0);
        // R5 wide pulsed ordering
        send(10'h201, 1'b1, 1'b0, 1'b0, 1'b0);
        send(10'h001, 1'b1, 1'b0, 1'b0, 1'b0);
        // R2 inputs change after acceptance
        send(10'h0F3, 1'b0, 1'b0, 1'b1, 1'b0);
        send(10'h2C5, 1'b1, 1'b1, 1'b1, 1'b0);
        // R11 valid held high through a busy period
        send(10'h35A, 1'b1, 1'b0, 1'b1, 1'b1);
        send(10'h0A5, 1'b0, 1'b1, 1'b0, 1'b1);
        repeat (5) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R12 watchdog actual=no_finish expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule